// File: doc/BRIEF.md
# Proportional-Integral Loop Filter for a Digital Phase-Locked Loop

This block is the loop filter of a discrete-time phase-locked loop. Each time a new sample arrives it takes a signed fixed-point phase error and returns a signed fixed-point phase estimate. Inside is a second-order recursive section in direct form II. Its denominator is a double integrator, so the feedback coefficients are fixed at -2 and +1. That leaves only a shift and two additions in the recursive path. The three feed-forward weights are elaboration-time parameters, chosen offline from the loop bandwidth, damping and gain.

Three state registers hold the recursion. On a valid sample the state shifts first: the middle register takes the lower one and the upper register takes the middle one. Then a new lower value is formed from the error and the two older values. The output is the weighted sum of the three freshly updated registers. It is rescaled to the error's step size and registered, so a result appears one clock after its sample. The double integrator grows without bound under a frequency offset, so both the state and the output clamp at their signed limits instead of wrapping.

Top module: `pi_loop_filter`

## Requirements
- R1: Synchronous active-high reset clears all three state registers, `phase_est` and `out_valid` to zero. They read zero at the first clock after reset is released.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was sampled high, and low otherwise.
- R3: While `in_valid` is low, `phase_est` and the state hold their values. The next valid sample continues the recursion as if no gap had occurred.
- R4: On a valid sample the state shifts first (upper := middle, middle := lower). The new lower value is then err + 2·(old lower) − (old middle).
- R5: `phase_est` = floor((B0·lower + B1·middle + B2·upper) / 2^22), computed from the registers as updated by that same sample.
- R6: The new lower state value saturates to the signed 32-bit range [−2^31, 2^31−1] and never wraps. With all three registers at a limit and a zero error, they stay at that limit.
- R7: `phase_est` saturates to the signed 32-bit range [−2^31, 2^31−1] and never wraps.
- R8: `phase_err` is a 16-bit two's-complement Q2.14 value. The weights B0, B1 and B2 are 24-bit signed Q1.22 parameters. One LSB of `phase_est` has the same weight as one LSB of `phase_err`. The default weights are 120293, 3355 and −116937.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new phase error is present this cycle |
| phase_err | input | 16 | Signed Q2.14 phase error |
| out_valid | output | 1 | `phase_est` holds a new result |
| phase_est | output | 32 | Signed phase estimate, LSB equal to the error LSB |

## Verification
Every result is due one clock after its sample: the state and the output register load on the same rising edge that samples `in_valid`. The driver changes inputs on falling edges and queues the bit-exact expected estimate for each sample. The monitor samples two nanoseconds after each rising edge. At that point the queue holds exactly the results due, so `out_valid` must equal "queue not empty" and the head entry must equal `phase_est`. During idle cycles the monitor requires `phase_est` to be unchanged. After long saturating runs, directed checks compare the held output with limit values worked out by hand.

// File: rtl/pll_lf_pkg.sv
package pll_lf_pkg;

    // default widths and formats
    localparam int unsigned ERR_W_DEF     = 16;   // Q2.14 error
    localparam int unsigned ST_W_DEF      = 32;   // state registers
    localparam int unsigned COEF_W_DEF    = 24;   // Q1.22 weights
    localparam int unsigned COEF_FRAC_DEF = 22;
    localparam int unsigned OUT_W_DEF     = 32;
    localparam int unsigned N_TAPS        = 3;
    localparam int unsigned WIDE_W        = 64;

    // default weights: bandwidth 0.01, damping 0.707, gain 1000, in Q1.22
    localparam int B0_DEF = 120293;
    localparam int B1_DEF = 3355;
    localparam int B2_DEF = -116937;

    typedef logic signed [WIDE_W-1:0] wide_t;

    // clamp a wide signed value to a w-bit signed range (w < 64)
    function automatic wide_t sat_to(input wide_t x, input int unsigned w);
        wide_t hi;
        wide_t lo;
        hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
        lo = -(wide_t'(1) <<< (w - 1));
        if (x > hi)      return hi;
        else if (x < lo) return lo;
        else             return x;
    endfunction

endpackage

// File: rtl/lf_state_update.sv
module lf_state_update
    import pll_lf_pkg::*;
#(
    parameter int unsigned ERR_W = ERR_W_DEF,
    parameter int unsigned ST_W  = ST_W_DEF
) (
    input  logic signed [ERR_W-1:0] err,
    input  logic signed [ST_W-1:0]  lower_q,
    input  logic signed [ST_W-1:0]  middle_q,
    output logic signed [ST_W-1:0]  lower_d
);
    // double pole at z=1: feedback is a shift and a subtract
    wide_t err_x;
    wide_t lo_x;
    wide_t mid_x;
    wide_t acc;

    always_comb begin
        err_x   = wide_t'(err);
        lo_x    = wide_t'(lower_q);
        mid_x   = wide_t'(middle_q);
        acc     = err_x + (lo_x <<< 1) - mid_x;
        lower_d = ST_W'(sat_to(acc, ST_W));
    end

endmodule

// File: rtl/lf_weighted_sum.sv
module lf_weighted_sum
    import pll_lf_pkg::*;
#(
    parameter int unsigned ST_W      = ST_W_DEF,
    parameter int unsigned COEF_W    = COEF_W_DEF,
    parameter int unsigned COEF_FRAC = COEF_FRAC_DEF,
    parameter int unsigned OUT_W     = OUT_W_DEF,
    parameter int          B0        = B0_DEF,
    parameter int          B1        = B1_DEF,
    parameter int          B2        = B2_DEF
) (
    input  logic signed [ST_W-1:0]  taps [N_TAPS],
    output logic signed [OUT_W-1:0] result
);
    localparam logic signed [COEF_W-1:0] WEIGHT [N_TAPS] =
        '{COEF_W'(B0), COEF_W'(B1), COEF_W'(B2)};

    wide_t prod [N_TAPS];
    wide_t total;
    wide_t scaled;

    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        assign prod[g] = wide_t'(taps[g]) * wide_t'(WEIGHT[g]);
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < N_TAPS; i++) begin
            total = total + prod[i];
        end
        scaled = total >>> COEF_FRAC;
        result = OUT_W'(sat_to(scaled, OUT_W));
    end

endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
    import pll_lf_pkg::*;
#(
    parameter int unsigned ERR_W     = ERR_W_DEF,
    parameter int unsigned ST_W      = ST_W_DEF,
    parameter int unsigned COEF_W    = COEF_W_DEF,
    parameter int unsigned COEF_FRAC = COEF_FRAC_DEF,
    parameter int unsigned OUT_W     = OUT_W_DEF,
    parameter int          B0        = B0_DEF,
    parameter int          B1        = B1_DEF,
    parameter int          B2        = B2_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [ERR_W-1:0] phase_err,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] phase_est
);
    typedef struct packed {
        logic signed [ST_W-1:0] lower;
        logic signed [ST_W-1:0] middle;
        logic signed [ST_W-1:0] upper;
    } lf_state_t;

    lf_state_t              st_q;
    lf_state_t              st_d;
    logic signed [ST_W-1:0] lower_next;
    logic signed [ST_W-1:0] taps [N_TAPS];
    logic signed [OUT_W-1:0] est_next;

    lf_state_update #(.ERR_W(ERR_W), .ST_W(ST_W)) u_update (
        .err      (phase_err),
        .lower_q  (st_q.lower),
        .middle_q (st_q.middle),
        .lower_d  (lower_next)
    );

    // shift first, then the fresh lower value
    always_comb begin
        st_d.upper  = st_q.middle;
        st_d.middle = st_q.lower;
        st_d.lower  = lower_next;
        taps[0]     = st_d.lower;
        taps[1]     = st_d.middle;
        taps[2]     = st_d.upper;
    end

    lf_weighted_sum #(
        .ST_W(ST_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .OUT_W(OUT_W),
        .B0(B0), .B1(B1), .B2(B2)
    ) u_sum (
        .taps   (taps),
        .result (est_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            phase_est <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                st_q      <= st_d;
                phase_est <= est_next;
            end
        end
    end

endmodule

// File: rtl/lf_chk.sv
module lf_chk #(
    parameter int unsigned ST_W  = 32,
    parameter int unsigned OUT_W = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] phase_est,
    input logic signed [ST_W-1:0]  lower,
    input logic signed [ST_W-1:0]  middle,
    input logic signed [ST_W-1:0]  upper
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && phase_est == '0 && lower == '0 &&
                 middle == '0 && upper == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_no_extra_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(phase_est) && $stable(lower) &&
                       $stable(middle) && $stable(upper)));

    a_r4_shift_order: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (middle == $past(lower) && upper == $past(middle)));

endmodule

bind pi_loop_filter lf_chk #(.ST_W(ST_W), .OUT_W(OUT_W)) u_lf_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .phase_est (phase_est),
    .lower     (st_q.lower),
    .middle    (st_q.middle),
    .upper     (st_q.upper)
);

// File: tb/test_pi_loop_filter.sv
module test_pi_loop_filter;

    localparam int  W0 = 120293, W1 = 3355, W2 = -116937;
    localparam int  WS = 8388607;          // largest Q1.22 weight
    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -64'sd2147483648;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] phase_err = '0;
    logic               out_valid, out_valid_s;
    logic signed [31:0] phase_est, phase_est_s;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    pi_loop_filter i_pi_loop_filter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .phase_err(phase_err),
        .out_valid(out_valid), .phase_est(phase_est)
    );

    pi_loop_filter #(.B0(WS), .B1(WS), .B2(WS)) i_pi_loop_filter_sat (
        .clk(clk), .rst(rst), .in_valid(in_valid), .phase_err(phase_err),
        .out_valid(out_valid_s), .phase_est(phase_est_s)
    );

    // reference model state
    longint m_lo = 0, m_mid = 0, m_up = 0;
    longint q_main [$];
    longint q_sat  [$];
    longint last_main = 0, last_sat = 0;

    function automatic longint clamp32(input longint x);
        if (x > SMAX) return SMAX;
        if (x < SMIN) return SMIN;
        return x;
    endfunction

    function automatic void model_step(input longint e);
        longint nl;
        nl    = clamp32(e + 2 * m_lo - m_mid);
        m_up  = m_mid;
        m_mid = m_lo;
        m_lo  = nl;
        q_main.push_back(clamp32((W0 * m_lo + W1 * m_mid + W2 * m_up) >>> 22));
        q_sat.push_back(clamp32((WS * (m_lo + m_mid + m_up)) >>> 22));
    endfunction

    function automatic void check(input string req, input string what,
                                  input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endfunction

    task automatic send(input int e);
        @(negedge clk);
        in_valid  = 1'b1;
        phase_err = 16'(e);
        model_step(longint'(e));
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        m_lo = 0; m_mid = 0; m_up = 0;
        q_main.delete();
        q_sat.delete();
        last_main = 0; last_sat = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // monitor: 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst) begin
                check("R2", "out_valid", longint'(out_valid), longint'(q_main.size() != 0));
                check("R2", "out_valid sat", longint'(out_valid_s), longint'(q_sat.size() != 0));
                if (q_main.size() != 0) begin
                    check(tag, "phase_est", longint'(phase_est), q_main.pop_front());
                    last_main = longint'(phase_est);
                end else begin
                    check("R3", "phase_est held", longint'(phase_est), last_main);
                end
                if (q_sat.size() != 0) begin
                    check("R7", "phase_est sat", longint'(phase_est_s), q_sat.pop_front());
                    last_sat = longint'(phase_est_s);
                end else begin
                    check("R3", "phase_est sat held", longint'(phase_est_s), last_sat);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        // R1: cleared state at the first clock after reset
        check("R1", "out_valid after reset", longint'(out_valid), 0);
        check("R1", "phase_est after reset", longint'(phase_est), 0);

        // R8: single most negative error from a zero state
        tag = "R8";
        send(-32768);
        idle(2);
        check("R8", "min error impulse", last_main, (longint'(W0) * -32768) >>> 22);

        // R4/R5: constant ramp of error, back to back
        do_reset();
        tag = "R4";
        for (int k = 0; k < 64; k++) send(k * 8);
        idle(3);

        // R3: gaps between samples, mixed signs
        tag = "R3";
        for (int k = 0; k < 40; k++) begin
            send((k % 2 == 0) ? -1500 + k * 37 : 900 - k * 11);
            idle(k % 4);
        end
        idle(2);

        // R5: alternating sign pattern
        tag = "R5";
        for (int k = 0; k < 30; k++) send((k % 2 == 0) ? 4000 : -4000);
        idle(2);

        // R6/R7: drive to positive saturation, then hold with zero error
        tag = "R6";
        for (int k = 0; k < 500; k++) send(32767);
        for (int k = 0; k < 20; k++) send(0);
        idle(2);
        check("R6", "positive state limit output", last_main, (SMAX * 6711) >>> 22);
        check("R7", "positive output limit", last_sat, SMAX);

        // negative saturation
        for (int k = 0; k < 1000; k++) send(-32768);
        for (int k = 0; k < 20; k++) send(0);
        idle(2);
        check("R6", "negative state limit output", last_main, (SMIN * 6711) >>> 22);
        check("R7", "negative output limit", last_sat, SMIN);

        // R1: reset in the middle of a run restarts from zero
        do_reset();
        @(posedge clk); #2;
        check("R1", "phase_est after mid reset", longint'(phase_est), 0);
        tag = "R1";
        for (int k = 0; k < 8; k++) send(100 * k - 350);
        idle(3);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule